// File: doc/BRIEF.md
# Iterative Virtual-Branch Indirect Target Predictor

This block predicts the target of an indirect branch without a dedicated indirect-target table. It treats one indirect branch as a chain of up to four virtual conditional branches. Each link in the chain has its own virtual program counter, formed by mixing the real branch address with a per-step hash constant. Each link looks up a candidate target in a shared target buffer and a taken/not-taken guess in a shared table of 2-bit saturating counters. The first link that both hits in the target buffer and is guessed taken supplies the predicted target. A link guessed not taken shifts a zero into a private copy of the global history, and the search moves on. The search stops with no prediction when the buffer misses or the step limit is reached.

The block evaluates one link per clock cycle, so a prediction takes one to four cycles. A `busy` output covers that window. When the real target of a branch is resolved, the caller presents it on the update port. The engine then replays the same chain of links. Links whose stored target differs from the resolved one are trained toward not taken. The matching link is trained toward taken. If no link matches, the target is installed in a new link. A branch therefore occupies one buffer slot for each distinct target it has shown.

Top module: `vpc_predictor`

## Requirements
- R1: After reset, `busy` and `resp_valid` are 0, every target-buffer slot is empty, and every direction counter holds 1 (weakly not taken). The first prediction after reset therefore reports no target after a single step.
- R2: Step 0 uses the branch address and the history exactly as given. Step k (k = 1..3) uses virtual address = address XOR ((k × HASH_MUL) mod 2^PC_W), with HASH_MUL = 0x9E37 by default. Its virtual history is the given history shifted left by k, with zeros filling from bit 0 and bits above HIST_W dropped.
- R3: The target buffer is indexed by virtual-address bits [BTB_IDX_W-1:0] and tagged with the remaining upper bits. A slot hits only when it is valid and its tag matches. The direction counter is selected by bits [DIR_IDX_W-1:0] of (virtual address XOR zero-extended virtual history). A counter value of 2 or 3 means taken.
- R4: The search ends at the first step that hits in the target buffer with a taken counter. The response then carries `resp_hit` = 1 and that slot's target.
- R5: If a step misses in the target buffer, or step 3 ends without a taken hit, the response carries `resp_hit` = 0.
- R6: A command is accepted on a rising edge where `busy` is 0. If the search or replay ends at step f, `busy` is 1 for exactly f+1 cycles after acceptance. A prediction's `resp_valid` is then high for exactly one cycle, the cycle in which `busy` has returned to 0. An update never raises `resp_valid`.
- R7: While `busy` is 1, `req_valid` and `upd_valid` are ignored: no extra response is produced and the running operation is not disturbed.
- R8: If `req_valid` and `upd_valid` are both 1 on an accepting edge, the update is taken and the request is dropped; no response follows for it.
- R9: During an update replay, a step that hits with a target different from the resolved one decrements its counter, saturating at 0, and the replay continues. A step that hits with the resolved target increments its counter, saturating at 3, and the replay ends.
- R10: If no step matches, the resolved target is written at the first step whose slot misses. If all four steps hit, it overwrites the slot of step 3. In either case that step's counter is incremented and the replay ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Prediction request |
| req_pc | input | PC_W | Address of the indirect branch to predict |
| req_hist | input | HIST_W | Global branch history for the request |
| upd_valid | input | 1 | Training command carrying a resolved target |
| upd_pc | input | PC_W | Address of the resolved indirect branch |
| upd_hist | input | HIST_W | Global history seen when that branch was predicted |
| upd_target | input | TGT_W | Resolved target |
| busy | output | 1 | A search or replay is in progress; commands are ignored |
| resp_valid | output | 1 | One-cycle pulse marking a finished prediction |
| resp_hit | output | 1 | A target was predicted |
| resp_target | output | TGT_W | Predicted target, 0 when there is no hit |

## Verification
Two commands can arrive together in one idle cycle: a prediction request and a training update. The bench drives both on the same edge and judges the result in two ways. The reference model must see the update's replay length on `busy`, and no response pulse may appear for the dropped request. A second overlap is a request pulsed in the middle of an update replay. It must leave the replay length and the table contents unchanged, and these are then read back through a later prediction. Throughout, a behavioural model of the tables predicts `busy`, `resp_valid`, `resp_hit` and `resp_target` on every cycle, under both directed chains and a random mix of commands.

// File: rtl/vpc_pkg.sv
package vpc_pkg;

   typedef enum logic [1:0] {
      VS_IDLE = 2'd0,
      VS_PRED = 2'd1,
      VS_UPD  = 2'd2
   } vpc_state_e;

   localparam logic [1:0] CTR_WEAK_NT = 2'b01;
   localparam logic [1:0] CTR_MAX     = 2'b11;

   // saturating 2-bit step toward taken (up=1) or not taken (up=0)
   function automatic logic [1:0] ctr_step(input logic [1:0] cur, input logic up);
      logic [1:0] nxt;
      if (up) nxt = (cur == CTR_MAX) ? cur : cur + 2'd1;
      else    nxt = (cur == 2'b00)   ? cur : cur - 2'd1;
      return nxt;
   endfunction

endpackage

// File: rtl/vpc_gen.sv
module vpc_gen #(
   parameter int unsigned PC_W      = 16,
   parameter int unsigned HIST_W    = 8,
   parameter int unsigned ITER_W    = 2,
   parameter int unsigned BTB_IDX_W = 5,
   parameter int unsigned DIR_IDX_W = 8,
   parameter int unsigned HASH_MUL  = 32'h9E37,
   localparam int unsigned TAG_W    = PC_W - BTB_IDX_W
) (
   input  logic [PC_W-1:0]      pc,
   input  logic [HIST_W-1:0]    vhist,
   input  logic [ITER_W-1:0]    iter,
   output logic [BTB_IDX_W-1:0] btb_idx,
   output logic [TAG_W-1:0]     btb_tag,
   output logic [DIR_IDX_W-1:0] dir_idx
);

   logic [PC_W-1:0] mul_c;
   logic [PC_W-1:0] iter_ext;
   logic [PC_W-1:0] hash_v;
   logic [PC_W-1:0] vpc;
   logic [PC_W-1:0] hist_ext;
   logic [PC_W-1:0] mix;

   assign mul_c    = PC_W'(HASH_MUL);
   assign iter_ext = PC_W'(iter);
   assign hash_v   = mul_c * iter_ext;   // step 0 yields zero: real address
   assign vpc      = pc ^ hash_v;

   generate
      if (HIST_W >= PC_W) begin : g_hist_trunc
         assign hist_ext = vhist[PC_W-1:0];
      end else begin : g_hist_zext
         assign hist_ext = {{(PC_W-HIST_W){1'b0}}, vhist};
      end
   endgenerate

   assign mix     = vpc ^ hist_ext;
   assign btb_idx = vpc[BTB_IDX_W-1:0];
   assign btb_tag = vpc[PC_W-1:BTB_IDX_W];
   assign dir_idx = mix[DIR_IDX_W-1:0];

endmodule

// File: rtl/vpc_dir_table.sv
module vpc_dir_table
   import vpc_pkg::*;
#(
   parameter int unsigned DIR_IDX_W = 8,
   localparam int unsigned ENTRIES  = 1 << DIR_IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [DIR_IDX_W-1:0] rd_idx,
   output logic [1:0]           rd_ctr,
   input  logic                 wr_en,
   input  logic [DIR_IDX_W-1:0] wr_idx,
   input  logic                 wr_up
);

   logic [1:0] ctr_mem [ENTRIES];

   assign rd_ctr = ctr_mem[rd_idx];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         for (int i = 0; i < ENTRIES; i++) ctr_mem[i] <= CTR_WEAK_NT;
      end else if (wr_en) begin
         ctr_mem[wr_idx] <= ctr_step(ctr_mem[wr_idx], wr_up);
      end
   end

   AST_CTR_SATURATES: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && wr_up && (wr_idx == rd_idx) && (rd_ctr == CTR_MAX))
      |=> (ctr_mem[$past(wr_idx)] == CTR_MAX)); // R9

   AST_CTR_FLOOR: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_en && !wr_up && (wr_idx == rd_idx) && (rd_ctr == 2'b00))
      |=> (ctr_mem[$past(wr_idx)] == 2'b00)); // R9

endmodule

// File: rtl/vpc_btb.sv
module vpc_btb #(
   parameter int unsigned BTB_IDX_W = 5,
   parameter int unsigned TAG_W     = 11,
   parameter int unsigned TGT_W     = 16,
   parameter bit          TAGGED    = 1'b1,
   localparam int unsigned ENTRIES  = 1 << BTB_IDX_W
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [BTB_IDX_W-1:0] rd_idx,
   input  logic [TAG_W-1:0]     rd_tag,
   output logic                 rd_hit,
   output logic [TGT_W-1:0]     rd_tgt,
   input  logic                 wr_en,
   input  logic [BTB_IDX_W-1:0] wr_idx,
   input  logic [TAG_W-1:0]     wr_tag,
   input  logic [TGT_W-1:0]     wr_tgt
);

   logic [ENTRIES-1:0] valid_q;
   logic [TGT_W-1:0]   tgt_mem [ENTRIES];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         valid_q <= '0;
         for (int i = 0; i < ENTRIES; i++) tgt_mem[i] <= '0;
      end else if (wr_en) begin
         valid_q[wr_idx] <= 1'b1;
         tgt_mem[wr_idx] <= wr_tgt;
      end
   end

   assign rd_tgt = tgt_mem[rd_idx];

   generate
      if (TAGGED) begin : g_tagged
         logic [TAG_W-1:0] tag_mem [ENTRIES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int i = 0; i < ENTRIES; i++) tag_mem[i] <= '0;
            end else if (wr_en) begin
               tag_mem[wr_idx] <= wr_tag;
            end
         end
         assign rd_hit = valid_q[rd_idx] && (tag_mem[rd_idx] == rd_tag);
      end else begin : g_untagged
         logic unused_tags;
         assign unused_tags = ^{rd_tag, wr_tag};
         assign rd_hit      = valid_q[rd_idx];
      end
   endgenerate

   AST_WRITE_FILLS_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
      wr_en |=> valid_q[$past(wr_idx)]); // R10

endmodule

// File: rtl/vpc_predictor.sv
module vpc_predictor
   import vpc_pkg::*;
#(
   parameter int unsigned PC_W       = 16,
   parameter int unsigned TGT_W      = 16,
   parameter int unsigned HIST_W     = 8,
   parameter int unsigned BTB_IDX_W  = 5,
   parameter int unsigned DIR_IDX_W  = 8,
   parameter int unsigned MAX_ITER   = 4,
   parameter int unsigned HASH_MUL   = 32'h9E37,
   parameter bit          BTB_TAGGED = 1'b1,
   localparam int unsigned ITER_W    = (MAX_ITER > 1) ? $clog2(MAX_ITER) : 1,
   localparam int unsigned TAG_W     = PC_W - BTB_IDX_W
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic [PC_W-1:0]   req_pc,
   input  logic [HIST_W-1:0] req_hist,
   input  logic              upd_valid,
   input  logic [PC_W-1:0]   upd_pc,
   input  logic [HIST_W-1:0] upd_hist,
   input  logic [TGT_W-1:0]  upd_target,
   output logic              busy,
   output logic              resp_valid,
   output logic              resp_hit,
   output logic [TGT_W-1:0]  resp_target
);

   // elaboration-time parameter checks
   generate
      if (MAX_ITER < 1 || MAX_ITER > (1 << ITER_W)) begin : g_bad_iter
         $error("vpc_predictor: MAX_ITER out of range");
      end
      if (BTB_IDX_W < 1 || BTB_IDX_W >= PC_W) begin : g_bad_btb
         $error("vpc_predictor: BTB_IDX_W must lie in 1..PC_W-1");
      end
      if (DIR_IDX_W < 1 || DIR_IDX_W > PC_W) begin : g_bad_dir
         $error("vpc_predictor: DIR_IDX_W must lie in 1..PC_W");
      end
      if (HIST_W < 2) begin : g_bad_hist
         $error("vpc_predictor: HIST_W must be at least 2");
      end
   endgenerate

   vpc_state_e        state_q;
   logic [ITER_W-1:0] iter_q;
   logic [PC_W-1:0]   pc_q;
   logic [HIST_W-1:0] vhist_q;
   logic [TGT_W-1:0]  tgt_q;
   logic              resp_valid_q;
   logic              resp_hit_q;
   logic [TGT_W-1:0]  resp_tgt_q;

   logic [BTB_IDX_W-1:0] bt_idx;
   logic [TAG_W-1:0]     bt_tag;
   logic [DIR_IDX_W-1:0] dr_idx;
   logic                 bt_hit;
   logic [TGT_W-1:0]     bt_tgt;
   logic [1:0]           dr_ctr;

   logic last_step;
   logic tgt_match;
   logic pred_take;
   logic pred_stop;
   logic upd_install;
   logic upd_stop;
   logic step_stop;
   logic train_en;
   logic train_up;
   logic bt_wr_en;

   vpc_gen #(
      .PC_W      (PC_W),
      .HIST_W    (HIST_W),
      .ITER_W    (ITER_W),
      .BTB_IDX_W (BTB_IDX_W),
      .DIR_IDX_W (DIR_IDX_W),
      .HASH_MUL  (HASH_MUL)
   ) u_gen (
      .pc      (pc_q),
      .vhist   (vhist_q),
      .iter    (iter_q),
      .btb_idx (bt_idx),
      .btb_tag (bt_tag),
      .dir_idx (dr_idx)
   );

   vpc_btb #(
      .BTB_IDX_W (BTB_IDX_W),
      .TAG_W     (TAG_W),
      .TGT_W     (TGT_W),
      .TAGGED    (BTB_TAGGED)
   ) u_btb (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (bt_idx),
      .rd_tag (bt_tag),
      .rd_hit (bt_hit),
      .rd_tgt (bt_tgt),
      .wr_en  (bt_wr_en),
      .wr_idx (bt_idx),
      .wr_tag (bt_tag),
      .wr_tgt (tgt_q)
   );

   vpc_dir_table #(
      .DIR_IDX_W (DIR_IDX_W)
   ) u_dir (
      .clk    (clk),
      .rst_n  (rst_n),
      .rd_idx (dr_idx),
      .rd_ctr (dr_ctr),
      .wr_en  (train_en),
      .wr_idx (dr_idx),
      .wr_up  (train_up)
   );

   // one virtual branch is resolved per cycle
   always_comb begin
      last_step   = (iter_q == ITER_W'(MAX_ITER - 1));
      tgt_match   = bt_hit && (bt_tgt == tgt_q);
      pred_take   = bt_hit && dr_ctr[1];
      pred_stop   = !bt_hit || pred_take || last_step;
      upd_install = !bt_hit || (last_step && !tgt_match);
      upd_stop    = tgt_match || upd_install;
      step_stop   = (state_q == VS_PRED) ? pred_stop : upd_stop;
      train_en    = (state_q == VS_UPD);
      train_up    = upd_stop;
      bt_wr_en    = (state_q == VS_UPD) && upd_install;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q      <= VS_IDLE;
         iter_q       <= '0;
         pc_q         <= '0;
         vhist_q      <= '0;
         tgt_q        <= '0;
         resp_valid_q <= 1'b0;
         resp_hit_q   <= 1'b0;
         resp_tgt_q   <= '0;
      end else begin
         resp_valid_q <= 1'b0;
         case (state_q)
            VS_IDLE: begin
               iter_q <= '0;
               if (upd_valid) begin
                  state_q <= VS_UPD;
                  pc_q    <= upd_pc;
                  vhist_q <= upd_hist;
                  tgt_q   <= upd_target;
               end else if (req_valid) begin
                  state_q <= VS_PRED;
                  pc_q    <= req_pc;
                  vhist_q <= req_hist;
               end
            end
            default: begin
               if (step_stop) begin
                  state_q <= VS_IDLE;
                  if (state_q == VS_PRED) begin
                     resp_valid_q <= 1'b1;
                     resp_hit_q   <= pred_take;
                     resp_tgt_q   <= pred_take ? bt_tgt : '0;
                  end
               end else begin
                  iter_q  <= iter_q + ITER_W'(1);
                  vhist_q <= vhist_q << 1;
               end
            end
         endcase
      end
   end

   assign busy        = (state_q != VS_IDLE);
   assign resp_valid  = resp_valid_q;
   assign resp_hit    = resp_hit_q;
   assign resp_target = resp_tgt_q;

   AST_RESP_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |=> !resp_valid); // R6

   AST_RESP_AFTER_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
      resp_valid |-> !busy); // R6

   AST_STEP_LIMIT: assert property (@(posedge clk) disable iff (!rst_n)
      busy |-> (iter_q <= ITER_W'(MAX_ITER - 1))); // R5

   AST_HIST_ZERO_SHIFT: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && $past(busy) && (iter_q != '0)) |-> (vhist_q == ($past(vhist_q) << 1))); // R2

   AST_UPDATE_PRIORITY: assert property (@(posedge clk) disable iff (!rst_n)
      (!busy && upd_valid) |=> (busy && !resp_valid && (state_q == VS_UPD))); // R8

   AST_BUSY_HOLDS_CMD: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !step_stop) |=> ($stable(pc_q) && $stable(tgt_q) && busy)); // R7

   AST_TAKEN_ENDS_SEARCH: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == VS_PRED) && bt_hit && dr_ctr[1]) |=> (resp_valid && resp_hit)); // R4

   AST_MISS_NO_TARGET: assert property (@(posedge clk) disable iff (!rst_n)
      ((state_q == VS_PRED) && !bt_hit) |=> (resp_valid && !resp_hit)); // R5

endmodule

// File: tb/vpc_predictor_tb.sv
module vpc_predictor_tb;

   localparam int PC_W = 16;
   localparam int TGT_W = 16;
   localparam int HIST_W = 8;
   localparam int BI_W = 5;
   localparam int DI_W = 8;
   localparam int STEPS = 4;
   localparam int HMUL = 32'h9E37;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic req_valid = 1'b0;
   logic [PC_W-1:0] req_pc = '0;
   logic [HIST_W-1:0] req_hist = '0;
   logic upd_valid = 1'b0;
   logic [PC_W-1:0] upd_pc = '0;
   logic [HIST_W-1:0] upd_hist = '0;
   logic [TGT_W-1:0] upd_target = '0;
   logic busy, resp_valid, resp_hit;
   logic [TGT_W-1:0] resp_target;

   always #4 clk = ~clk;   // 125 MHz

   vpc_predictor u_dut (
      .clk(clk), .rst_n(rst_n),
      .req_valid(req_valid), .req_pc(req_pc), .req_hist(req_hist),
      .upd_valid(upd_valid), .upd_pc(upd_pc), .upd_hist(upd_hist), .upd_target(upd_target),
      .busy(busy), .resp_valid(resp_valid), .resp_hit(resp_hit), .resp_target(resp_target)
   );

   int n_cmp = 0;
   int n_bad = 0;
   int cycles = 0;

   task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_cmp++;
      if (act !== exp) begin
         n_bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   // ---------------- behavioural reference model ----------------
   bit             m_val [1<<BI_W];
   int unsigned    m_tag [1<<BI_W];
   int unsigned    m_tgt [1<<BI_W];
   int             m_ctr [1<<DI_W];
   int  m_busy = 0;
   bit  m_rv = 0, m_is_pred = 0, m_ph = 0, m_hit_o = 0;
   int unsigned m_pt = 0, m_tgt_o = 0;

   function automatic int unsigned vaddr(input int unsigned pc, input int k);
      return (pc ^ (k * HMUL)) & 32'hFFFF;
   endfunction

   function automatic int unsigned slot_of(input int unsigned va);
      return va & ((1 << BI_W) - 1);
   endfunction

   function automatic int unsigned ctr_of(input int unsigned va, input int unsigned h, input int k);
      int unsigned vh;
      vh = (h << k) & ((1 << HIST_W) - 1);
      return (va ^ vh) & ((1 << DI_W) - 1);
   endfunction

   function automatic bit hits(input int unsigned va);
      return m_val[slot_of(va)] && (m_tag[slot_of(va)] == (va >> BI_W));
   endfunction

   task automatic model_predict(input int unsigned pc, input int unsigned h,
                                output int f, output bit ph, output int unsigned pt);
      ph = 0; pt = 0; f = STEPS - 1;
      for (int k = 0; k < STEPS; k++) begin
         int unsigned va;
         va = vaddr(pc, k);
         if (!hits(va)) begin f = k; break; end
         if (m_ctr[ctr_of(va, h, k)] >= 2) begin
            f = k; ph = 1; pt = m_tgt[slot_of(va)]; break;
         end
      end
   endtask

   task automatic model_update(input int unsigned pc, input int unsigned h,
                               input int unsigned t, output int f);
      f = STEPS - 1;
      for (int k = 0; k < STEPS; k++) begin
         int unsigned va, ci;
         va = vaddr(pc, k);
         ci = ctr_of(va, h, k);
         if (hits(va) && m_tgt[slot_of(va)] == t) begin
            if (m_ctr[ci] < 3) m_ctr[ci]++;
            f = k; break;
         end
         if (!hits(va) || k == STEPS - 1) begin
            m_val[slot_of(va)] = 1;
            m_tag[slot_of(va)] = va >> BI_W;
            m_tgt[slot_of(va)] = t;
            if (m_ctr[ci] < 3) m_ctr[ci]++;
            f = k; break;
         end
         if (m_ctr[ci] > 0) m_ctr[ci]--;
      end
   endtask

   always @(posedge clk) begin
      int f;
      if (!rst_n) begin
         for (int i = 0; i < (1 << BI_W); i++) begin m_val[i] = 0; m_tag[i] = 0; m_tgt[i] = 0; end
         for (int i = 0; i < (1 << DI_W); i++) m_ctr[i] = 1;
         m_busy = 0; m_rv = 0;
      end else begin
         m_rv = 0;
         if (m_busy > 0) begin
            m_busy--;
            if (m_busy == 0 && m_is_pred) begin m_rv = 1; m_hit_o = m_ph; m_tgt_o = m_pt; end
         end else if (upd_valid) begin
            model_update(upd_pc, upd_hist, upd_target, f);
            m_busy = f + 1; m_is_pred = 0;
         end else if (req_valid) begin
            model_predict(req_pc, req_hist, f, m_ph, m_pt);
            m_busy = f + 1; m_is_pred = 1;
         end
      end
   end

   always @(negedge clk) begin
      cycles++;
      if (rst_n) begin
         chk("R6 busy vs model", busy, (m_busy > 0));
         chk("R6 resp_valid vs model", resp_valid, m_rv);
         if (m_rv) begin
            chk("R4/R5 resp_hit vs model", resp_hit, m_hit_o);
            if (m_hit_o) chk("R4 resp_target vs model", resp_target, m_tgt_o);
         end
      end
   end

   // ---------------- directed stimulus helpers ----------------
   task automatic wait_idle();
      while (busy) @(negedge clk);
   endtask

   task automatic predict(input int unsigned pc, input int unsigned h,
                          input bit e_hit, input int unsigned e_tgt, input int e_busy, input string tag);
      int cnt;
      wait_idle();
      req_valid = 1; req_pc = pc[PC_W-1:0]; req_hist = h[HIST_W-1:0];
      @(negedge clk);
      req_valid = 0;
      cnt = 0;
      while (!resp_valid && cnt < 20) begin
         if (busy) cnt++;
         @(negedge clk);
      end
      chk({tag, " busy cycles"}, cnt, e_busy);
      chk({tag, " resp_hit"}, resp_hit, e_hit);
      if (e_hit) chk({tag, " resp_target"}, resp_target, e_tgt);
   endtask

   task automatic train(input int unsigned pc, input int unsigned h, input int unsigned t,
                        input int e_busy, input string tag);
      int cnt;
      wait_idle();
      upd_valid = 1; upd_pc = pc[PC_W-1:0]; upd_hist = h[HIST_W-1:0]; upd_target = t[TGT_W-1:0];
      @(negedge clk);
      upd_valid = 0;
      cnt = 0;
      while (busy && cnt < 20) begin cnt++; @(negedge clk); end
      chk({tag, " replay cycles"}, cnt, e_busy);
   endtask

   localparam int unsigned PA = 16'h1234;
   localparam int unsigned HA = 8'h0F;

   initial begin
      repeat (3) @(negedge clk);
      chk("R1 busy after reset", busy, 0);
      chk("R1 resp_valid after reset", resp_valid, 0);
      rst_n = 1;
      @(negedge clk);
      chk("R1 idle after release", busy, 0);

      predict(PA, HA, 0, 0, 1, "R1 R5 empty table one step");
      train(PA, HA, 16'hA001, 1, "R10 install at step 0");
      predict(PA, HA, 1, 16'hA001, 1, "R4 R3 hit step 0");
      train(PA, HA, 16'hB002, 2, "R9 R10 second target");
      predict(PA, HA, 1, 16'hB002, 2, "R2 R9 virtual step 1");
      train(PA, HA, 16'hC003, 3, "R10 third target");
      predict(PA, HA, 1, 16'hC003, 3, "R2 virtual step 2");
      // matching replay at step 2: counters at steps 0/1 decrement (R9 saturation at 0)
      train(PA, HA, 16'hC003, 3, "R9 match ends replay");

      // R8: request and update on the same idle edge; update wins
      wait_idle();
      req_valid = 1; req_pc = PA[PC_W-1:0]; req_hist = HA[HIST_W-1:0];
      upd_valid = 1; upd_pc = PA[PC_W-1:0]; upd_hist = HA[HIST_W-1:0]; upd_target = 16'hC003;
      @(negedge clk);
      req_valid = 0; upd_valid = 0;
      for (int i = 0; i < 8; i++) begin
         chk("R8 dropped request gives no response", resp_valid, 0);
         @(negedge clk);
      end

      // R7: request pulsed in the middle of an update replay is ignored
      wait_idle();
      upd_valid = 1; upd_pc = PA[PC_W-1:0]; upd_hist = HA[HIST_W-1:0]; upd_target = 16'hD004;
      @(negedge clk);
      upd_valid = 0;
      @(negedge clk);
      req_valid = 1; req_pc = PA[PC_W-1:0]; req_hist = HA[HIST_W-1:0];
      @(negedge clk);
      req_valid = 0;
      for (int i = 0; i < 6; i++) begin
         chk("R7 no response from ignored request", resp_valid, 0);
         @(negedge clk);
      end
      predict(PA, HA, 1, 16'hC003, 3, "R7 R9 tables undisturbed");
      train(PA, HA, 16'hE005, 4, "R10 overwrite at last step");
      predict(PA, HA, 1, 16'hE005, 4, "R10 R2 hit at step 3");
      predict(PA, 0, 0, 0, 4, "R5 four steps all not taken");
      predict(16'h0777, HA, 0, 0, 1, "R3 R5 tag miss other branch");

      // random mix compared against the model every cycle
      for (int i = 0; i < 4000; i++) begin
         int unsigned sel;
         sel = $urandom % 4;
         req_valid = ($urandom % 3 == 0);
         upd_valid = ($urandom % 4 == 0);
         req_pc  = (sel == 0) ? 16'h1234 : (sel == 1) ? 16'h0777 : (sel == 2) ? 16'h4321 : 16'hF00D;
         upd_pc  = req_pc;
         req_hist = ($urandom % 2) ? 8'h0F : 8'hA5;
         upd_hist = req_hist;
         upd_target = 16'h1000 + 16'($urandom % 6);
         @(negedge clk);
      end
      req_valid = 0; upd_valid = 0;
      repeat (10) @(negedge clk);

      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

   initial begin
      while (cycles < 150000) @(negedge clk);
      n_bad++;
      $display("FAIL watchdog actual=%0d expected=<150000 cycles", cycles);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
   end

endmodule